// File: doc/BRIEF.md
# Hysteretic Comparator Event Generator

This block holds the decision and event logic of a comparator peripheral. It works on digital codes, not voltages. Each clock it takes an unsigned input code and a reference code and keeps a two-valued state, ABOVE or BELOW. Hysteresis works in one of two ways. In differential mode a symmetric band is placed around the reference, set by a width register that can be switched on and off. In single-ended mode two thresholds are used: an upper one that moves the state out of BELOW and a lower one that moves it out of ABOVE.

Software-style controls set when the block runs. An enable level gates configuration writes. Start and stop pulses open and close the window in which state changes produce events. A sample pulse copies the present decision into a result bit. Each state change produces a one-cycle direction pulse and a one-cycle direction-independent crossing pulse.

Top module: `hyst_comparator`

## Requirements
- R1: A BELOW-to-ABOVE state change produces a one-cycle `ev_up` pulse, and an ABOVE-to-BELOW change produces a one-cycle `ev_down` pulse. Each pulse is high in the cycle after the clock edge that samples the input causing the change.
- R2: `ev_cross` pulses in that same cycle for a change in either direction, and at no other time.
- R3: `task_start` has an effect only while enabled. `task_stop` clears the started state and overrides a coincident start. No event fires while the block is not started.
- R4: On the edge that accepts a start, the state is loaded from an immediate comparison and no event is produced. In differential mode the state becomes ABOVE if `vin_p > vin_ref`. In single-ended mode it becomes ABOVE if `vin_p > cfg_thr_hi`.
- R5: A `task_sample` pulse copies the current state into `result` (1 = ABOVE) at the next edge.
- R6: In differential mode with hysteresis on, let h = width/2. ABOVE falls to BELOW only when `vin_p < ref-h`, saturated at 0. BELOW rises to ABOVE only when `vin_p > ref+h`, saturated at 4095.
- R7: In differential mode with hysteresis off, the state is ABOVE exactly when `vin_p > vin_ref`.
- R8: In single-ended mode (`cfg_diff`=0), BELOW rises only when `vin_p > cfg_thr_hi`, and ABOVE falls only when `vin_p < cfg_thr_lo`. `cfg_hyst_en` has no effect in this mode.
- R9: A `cfg_wr` is taken only while `enabled` is 0. While the block is enabled, a write leaves the configuration unchanged.
- R10: A write of `en_val`=0 while started is rejected, and `enabled` stays 1. Once stopped, the same write clears `enabled`.
- R11: After reset, `enabled`, `started`, `result` and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| task_sample | input | 1 | Sample pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_diff | input | 1 | 1 = differential, 0 = single-ended |
| cfg_hyst_en | input | 1 | Differential hysteresis enable |
| cfg_hyst_w | input | 12 | Differential hysteresis width |
| cfg_thr_hi | input | 12 | Single-ended upper threshold |
| cfg_thr_lo | input | 12 | Single-ended lower threshold |
| vin_p | input | 12 | Input code |
| vin_ref | input | 12 | Reference code |
| enabled | output | 1 | Enable state |
| started | output | 1 | Started state |
| ev_up | output | 1 | Upward change pulse |
| ev_down | output | 1 | Downward change pulse |
| ev_cross | output | 1 | Change pulse, either direction |
| result | output | 1 | Sampled decision |

## Verification
Every result of this block takes exactly one register stage. An input code, start, stop, sample, enable write or configuration write applied before edge k shows its effect on the outputs just after edge k. The bench therefore drives inputs on the falling edge and checks the outputs on the next falling edge. Because an event pulse lasts one cycle, each step can be checked on its own. A configuration write shows its effect on the following input step, one cycle later, so a rejected write is judged by the absence of the event it would have enabled.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;
  localparam int unsigned CODE_W = 12;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic  diff;
    logic  hyst_en;
    code_t hyst_w;
    code_t thr_hi;
    code_t thr_lo;
  } hcmp_cfg_t;
endpackage

// File: rtl/hcmp_ctrl.sv
module hcmp_ctrl
  import hcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_wr,
  input  logic      en_val,
  input  logic      task_start,
  input  logic      task_stop,
  input  logic      cfg_wr,
  input  hcmp_cfg_t cfg_in,
  output logic      enabled,
  output logic      started,
  output hcmp_cfg_t cfg
);
  logic      enabled_nxt;
  logic      started_nxt;
  hcmp_cfg_t cfg_nxt;
  logic      cfg_ce;

  // Configuration locked while enabled
  assign cfg_ce = cfg_wr & ~enabled;

  always_comb begin
    enabled_nxt = enabled;
    if (en_wr) begin
      if (en_val)        enabled_nxt = 1'b1;
      else if (!started) enabled_nxt = 1'b0;
    end
    started_nxt = started;
    if (task_stop)                 started_nxt = 1'b0;
    else if (task_start & enabled) started_nxt = 1'b1;
    cfg_nxt = cfg_ce ? cfg_in : cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      started <= 1'b0;
      cfg     <= '0;
    end else begin
      enabled <= enabled_nxt;
      started <= started_nxt;
      if (cfg_ce) cfg <= cfg_nxt;
    end
  end
endmodule

// File: rtl/hcmp_decide.sv
module hcmp_decide
  import hcmp_pkg::*;
(
  input  hcmp_cfg_t cfg,
  input  code_t     vin_p,
  input  code_t     vin_ref,
  input  logic      above,
  output logic      init_above,
  output logic      next_above
);
  localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

  code_t           half;
  logic [CODE_W:0] hi_wide;
  code_t           band_hi;
  code_t           band_lo;
  code_t           rise_thr;
  code_t           fall_thr;

  always_comb begin
    half    = cfg.hyst_w >> 1;
    hi_wide = {1'b0, vin_ref} + {1'b0, half};
    band_hi = (hi_wide > FULL) ? FULL[CODE_W-1:0] : hi_wide[CODE_W-1:0];
    band_lo = (vin_ref < half) ? '0 : vin_ref - half;

    if (cfg.diff) begin
      rise_thr = cfg.hyst_en ? band_hi : vin_ref;
      fall_thr = cfg.hyst_en ? band_lo : vin_ref;
    end else begin
      rise_thr = cfg.thr_hi;
      fall_thr = cfg.thr_lo;
    end

    init_above = cfg.diff ? (vin_p > vin_ref) : (vin_p > cfg.thr_hi);

    if (cfg.diff && !cfg.hyst_en) next_above = (vin_p > vin_ref);
    else if (above)               next_above = !(vin_p < fall_thr);
    else                          next_above = (vin_p > rise_thr);
  end
endmodule

// File: rtl/hcmp_track.sv
module hcmp_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic started,
  input  logic task_start,
  input  logic task_stop,
  input  logic task_sample,
  input  logic init_above,
  input  logic next_above,
  output logic above,
  output logic ev_up,
  output logic ev_down,
  output logic ev_cross,
  output logic result
);
  logic start_fire;
  logic run;
  logic above_nxt;
  logic up_nxt;
  logic down_nxt;
  logic cross_nxt;
  logic result_nxt;

  always_comb begin
    start_fire = task_start & enabled & ~started & ~task_stop;
    run        = started & ~task_stop;
    if (start_fire) above_nxt = init_above;
    else if (run)   above_nxt = next_above;
    else            above_nxt = above;
    up_nxt     = run & ~above &  next_above;
    down_nxt   = run &  above & ~next_above;
    cross_nxt  = up_nxt | down_nxt;
    result_nxt = task_sample ? above : result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above    <= 1'b0;
      ev_up    <= 1'b0;
      ev_down  <= 1'b0;
      ev_cross <= 1'b0;
      result   <= 1'b0;
    end else begin
      above    <= above_nxt;
      ev_up    <= up_nxt;
      ev_down  <= down_nxt;
      ev_cross <= cross_nxt;
      if (task_sample) result <= result_nxt;
    end
  end
endmodule

// File: rtl/hyst_comparator.sv
module hyst_comparator
  import hcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              task_start,
  input  logic              task_stop,
  input  logic              task_sample,
  input  logic              cfg_wr,
  input  logic              cfg_diff,
  input  logic              cfg_hyst_en,
  input  logic [CODE_W-1:0] cfg_hyst_w,
  input  logic [CODE_W-1:0] cfg_thr_hi,
  input  logic [CODE_W-1:0] cfg_thr_lo,
  input  logic [CODE_W-1:0] vin_p,
  input  logic [CODE_W-1:0] vin_ref,
  output logic              enabled,
  output logic              started,
  output logic              ev_up,
  output logic              ev_down,
  output logic              ev_cross,
  output logic              result
);
  logic [1:0] rst_sync;
  logic       rst_n_int;
  hcmp_cfg_t  cfg_in;
  hcmp_cfg_t  cfg;
  logic       above;
  logic       init_above;
  logic       next_above;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign cfg_in = '{diff: cfg_diff, hyst_en: cfg_hyst_en, hyst_w: cfg_hyst_w,
                    thr_hi: cfg_thr_hi, thr_lo: cfg_thr_lo};

  hcmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .en_wr(en_wr), .en_val(en_val),
    .task_start(task_start), .task_stop(task_stop), .cfg_wr(cfg_wr),
    .cfg_in(cfg_in), .enabled(enabled), .started(started), .cfg(cfg)
  );

  hcmp_decide u_decide (
    .cfg(cfg), .vin_p(vin_p), .vin_ref(vin_ref), .above(above),
    .init_above(init_above), .next_above(next_above)
  );

  hcmp_track u_track (
    .clk(clk), .rst_n(rst_n_int), .enabled(enabled), .started(started),
    .task_start(task_start), .task_stop(task_stop), .task_sample(task_sample),
    .init_above(init_above), .next_above(next_above), .above(above),
    .ev_up(ev_up), .ev_down(ev_down), .ev_cross(ev_cross), .result(result)
  );
endmodule

// File: rtl/hcmp_chk.sv
module hcmp_chk (
  input logic clk,
  input logic rst_n,
  input logic en_wr,
  input logic en_val,
  input logic enabled,
  input logic started,
  input logic ev_up,
  input logic ev_down,
  input logic ev_cross
);
  p_dir_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_up && ev_down));

  p_up_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up |=> !ev_up);

  p_cross_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cross |-> (ev_up || ev_down));

  p_dir_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up || ev_down) |-> ev_cross);

  p_event_started_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_cross) |-> $past(started));

  p_disable_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (started && en_wr && !en_val) |=> enabled);
endmodule

bind hyst_comparator hcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
  .enabled(enabled), .started(started),
  .ev_up(ev_up), .ev_down(ev_down), .ev_cross(ev_cross)
);

// File: tb/tb_hyst_comparator.sv
module tb_hyst_comparator;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {vin_p, up, down, cross}: diff mode, ref 2000, width 100 -> band 1950..2050
  localparam logic [14:0] VEC [NVEC] = '{
    {12'd2040, 3'b000}, {12'd2051, 3'b101}, {12'd2100, 3'b000},
    {12'd1960, 3'b000}, {12'd1949, 3'b011}, {12'd1950, 3'b000},
    {12'd2050, 3'b000}, {12'd2051, 3'b101}
  };

  logic clk = 1'b0;
  logic rst_n, en_wr, en_val, task_start, task_stop, task_sample, cfg_wr;
  logic cfg_diff, cfg_hyst_en;
  logic [11:0] cfg_hyst_w, cfg_thr_hi, cfg_thr_lo, vin_p, vin_ref;
  logic enabled, started, ev_up, ev_down, ev_cross, result;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyst_comparator dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic chk_ev(string req, logic [2:0] exp);
    chk(req, {1'b0, ev_up, ev_down, ev_cross}, {1'b0, exp});
  endtask

  task automatic set_cfg(logic d, logic h, logic [11:0] w, logic [11:0] hi, logic [11:0] lo);
    cfg_wr = 1'b1; cfg_diff = d; cfg_hyst_en = h; cfg_hyst_w = w;
    cfg_thr_hi = hi; cfg_thr_lo = lo;
    tick(); cfg_wr = 1'b0;
  endtask

  task automatic wr_en(logic v);
    en_wr = 1'b1; en_val = v; tick(); en_wr = 1'b0;
  endtask

  task automatic pulse_start();
    task_start = 1'b1; tick(); task_start = 1'b0;
  endtask

  task automatic pulse_stop();
    task_stop = 1'b1; tick(); task_stop = 1'b0;
  endtask

  task automatic pulse_sample();
    task_sample = 1'b1; tick(); task_sample = 1'b0;
  endtask

  task automatic step(logic [11:0] v);
    vin_p = v; tick();
  endtask

  initial begin
    rst_n = 1'b0; en_wr = 0; en_val = 0; task_start = 0; task_stop = 0;
    task_sample = 0; cfg_wr = 0; cfg_diff = 0; cfg_hyst_en = 0;
    cfg_hyst_w = 0; cfg_thr_hi = 0; cfg_thr_lo = 0; vin_p = 0; vin_ref = 0;
    tick(); tick();
    chk("R11 reset", {enabled, started, result, ev_cross}, 4'b0000);
    chk_ev("R11 reset events", 3'b000);
    rst_n = 1'b1;
    tick(); tick(); tick();

    // Differential mode with hysteresis
    set_cfg(1'b1, 1'b1, 12'd100, 12'd0, 12'd0);
    wr_en(1'b1);
    vin_ref = 12'd2000; vin_p = 12'd1000;
    pulse_start();
    chk("R4 start no event", {1'b0, ev_up, ev_down, started}, 4'b0001);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][14:3]);
      chk_ev("R1 R2 R6 table", VEC[i][2:0]);
    end

    // Locked configuration: hysteresis-off write must not take effect
    set_cfg(1'b1, 1'b0, 12'd100, 12'd0, 12'd0);
    step(12'd1990);
    chk_ev("R9 cfg write ignored", 3'b000);
    pulse_sample();
    chk("R5 sample above", {3'b0, result}, 4'b0001);
    wr_en(1'b0);
    chk("R10 disable rejected", {3'b0, enabled}, 4'b0001);
    pulse_stop();
    chk("R3 stop", {3'b0, started}, 4'b0000);
    step(12'd1000);
    chk_ev("R3 no event stopped", 3'b000);
    wr_en(1'b0);
    chk("R10 disable after stop", {3'b0, enabled}, 4'b0000);

    // Single-ended mode, hyst enable set but ignored
    set_cfg(1'b0, 1'b1, 12'd100, 12'd3000, 12'd1000);
    wr_en(1'b1);
    vin_p = 12'd2000;
    pulse_start();
    chk_ev("R4 se start", 3'b000);
    pulse_sample();
    chk("R4 se initial below", {3'b0, result}, 4'b0000);
    step(12'd3001); chk_ev("R8 se rise", 3'b101);
    step(12'd2000); chk_ev("R8 se hold", 3'b000);
    step(12'd1000); chk_ev("R8 se lo edge", 3'b000);
    step(12'd999);  chk_ev("R8 se fall", 3'b011);
    pulse_stop();
    wr_en(1'b0);
    pulse_start();
    chk("R3 start needs enable", {3'b0, started}, 4'b0000);

    // Differential, hysteresis off
    set_cfg(1'b1, 1'b0, 12'd0, 12'd0, 12'd0);
    wr_en(1'b1);
    vin_ref = 12'd2000; vin_p = 12'd2500;
    pulse_start();
    chk_ev("R4 diff start above", 3'b000);
    pulse_sample();
    chk("R4 R5 initial above", {3'b0, result}, 4'b0001);
    step(12'd2000); chk_ev("R7 equal falls", 3'b011);
    step(12'd2001); chk_ev("R7 rise", 3'b101);

    // Saturation of the band
    pulse_stop();
    wr_en(1'b0);
    set_cfg(1'b1, 1'b1, 12'd200, 12'd0, 12'd0);
    wr_en(1'b1);
    vin_ref = 12'd4050; vin_p = 12'd0;
    pulse_start();
    step(12'd4095); chk_ev("R6 upper saturation", 3'b000);
    vin_ref = 12'd50; tick();
    chk_ev("R6 rise after ref move", 3'b101);
    step(12'd0);    chk_ev("R6 lower saturation", 3'b000);

    // Stop wins over a coincident start
    pulse_stop();
    task_start = 1'b1; task_stop = 1'b1; tick();
    task_start = 1'b0; task_stop = 1'b0;
    chk("R3 stop overrides start", {3'b0, started}, 4'b0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule